// File: doc/BRIEF.md
# Mailbox Message Framing Engine

This engine carries one framed command out through a four-channel mailbox and, unless told not to, brings back the framed reply. A requester hands over up to eight 32-bit words and a no-reply flag, then pulses `start`. The first word is the header. Its bits [15:8] give the message length in words, and that length counts the header itself. Its other bytes hold the version (bits [7:0]), the command code (bits [23:16]) and the tag (bits [31:24]). These bytes pass through unchanged. Typical commands carry version 0x06 and tag 0x17, and replies carry tag 0xE1.

The mailbox offers four transmit slots, each with an empty flag, and four receive slots, each with a full flag. Word n of a message always uses slot n mod 4. The engine waits for the matching flag before it writes or reads each word. Each wait has its own cycle budget. The engine stops early in three cases: an oversized request, an oversized reply header, or a wait that runs out of budget. Success is judged from the lowest byte of the first reply payload word.

In the cycle after reset the engine pulses a strobe that tells the mailbox to clear its interrupt controls. From then on it works only by polling the flags.

Top module: `mbox_msg_engine`

## Requirements
- R1: The number of words sent equals the header size field (bits [15:8] of word 0), with a minimum of one. They are sent in order from word 0 upward. The header is always sent.
- R2: Word n uses channel n mod 4 on both transmit and receive. At most one transmit write strobe and at most one receive read strobe are high in any cycle.
- R3: A transmit write strobe for channel i is raised only while `tx_empty[i]` is high. While that flag is low, the engine waits without losing or reordering words.
- R4: A receive read strobe for channel i is raised only while `rx_full[i]` is high. Reply word n appears at `rsp_msg[n*32 +: 32]`.
- R5: A request whose size field is above 8 finishes with status 1 (invalid). Nothing is written to the mailbox.
- R6: A reply header whose size field is above 8 finishes with status 1. Reply word 0 then reads back as zero, and no further words are read.
- R7: With `no_resp` high, the engine finishes with status 0 right after the last transmit word and reads nothing.
- R8: After a full reply, the status is 0 when bits [7:0] of reply word 1 are zero, and 3 (I/O error) otherwise. The reply buffer is cleared at each accepted start, so a reply of one word gives status 0.
- R9: If a single wait lasts `TIMEOUT_CYC` cycles, the transfer stops with status 2 (timeout). The budget restarts for every word.
- R10: Status codes are 0 for ok, 1 for invalid, 2 for timeout and 3 for I/O error. `done` is a one-cycle pulse with `busy` low. `status` changes only in a cycle where `done` is high.
- R11: A `start` that arrives while `busy` is high is ignored.
- R12: `ctl_clr` is high for exactly the first cycle after reset is released and low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| no_resp | input | 1 | Skip the reply phase |
| req_msg | input | MAX_WORDS*32 | Request words, word n at [n*32 +: 32] |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code of the last transfer |
| rsp_msg | output | MAX_WORDS*32 | Reply words |
| ctl_clr | output | 1 | Post-reset strobe to clear mailbox interrupt controls |
| tx_empty | input | NCH | Transmit slot empty flags |
| tx_wr | output | NCH | Transmit slot write strobes |
| tx_data | output | 32 | Word being written |
| rx_full | input | NCH | Receive slot full flags |
| rx_rd | output | NCH | Receive slot read strobes |
| rx_data | input | NCH*32 | Receive slot contents, slot i at [i*32 +: 32] |

## Verification
The assertions check on every cycle that each strobe is one-hot and is gated by its flag. They also check that the status holds between completions, that `done` never overlaps `busy`, and that the post-reset strobe lasts a single cycle. Some behaviours need the bench's far-side model to show them. These are the word order and channel rotation, the size-limit refusals on both sides, the no-reply shortcut, the pass or fail decision from the payload byte, timeouts on a stalled transmit slot and on a silent receive slot, and a `start` ignored during a stall.

// File: rtl/mbox_msg_engine.sv
module mbox_msg_engine #(
  parameter int MAX_WORDS   = 8,
  parameter int NCH         = 4,
  parameter int TIMEOUT_CYC = 1250000,
  localparam int IW = $clog2(MAX_WORDS),
  localparam int CW = $clog2(NCH),
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   no_resp,
  input  logic [MAX_WORDS*32-1:0] req_msg,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             status,
  output logic [MAX_WORDS*32-1:0] rsp_msg,
  output logic                   ctl_clr,
  input  logic [NCH-1:0]         tx_empty,
  output logic [NCH-1:0]         tx_wr,
  output logic [31:0]            tx_data,
  input  logic [NCH-1:0]         rx_full,
  output logic [NCH-1:0]         rx_rd,
  input  logic [NCH*32-1:0]      rx_data
);
  localparam logic [1:0] ST_OK = 2'd0, ST_INV = 2'd1, ST_TMO = 2'd2, ST_IOE = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX, S_DONE} state_t;
  state_t st;

  logic [31:0]   msg [MAX_WORDS];
  logic [31:0]   rsp [MAX_WORDS];
  logic [IW-1:0] idx;
  logic [7:0]    tsize, rsize;
  logic          nresp, init_q;
  logic [TW-1:0] tmr;
  logic [1:0]    status_q;

  logic [CW-1:0] ch;
  logic [31:0]   cur_rx;
  logic [7:0]    nxt, rx_lim, lowb;
  logic          last_tx, last_rx, hdr_bad;

  assign ch      = idx[CW-1:0];
  assign cur_rx  = rx_data[ch*32 +: 32];
  assign nxt     = 8'(idx) + 8'd1;
  assign last_tx = nxt >= tsize;
  assign rx_lim  = (idx == '0) ? cur_rx[15:8] : rsize;
  assign last_rx = nxt >= rx_lim;
  assign hdr_bad = cur_rx[15:8] > 8'(MAX_WORDS);
  assign lowb    = (idx == IW'(1)) ? cur_rx[7:0] : rsp[1][7:0];

  assign tx_wr   = (st == S_TX && tx_empty[ch]) ? (NCH'(1) << ch) : '0;
  assign rx_rd   = (st == S_RX && rx_full[ch])  ? (NCH'(1) << ch) : '0;
  assign tx_data = msg[idx];
  assign busy    = (st == S_TX) || (st == S_RX);
  assign done    = (st == S_DONE);
  assign status  = status_q;
  assign ctl_clr = init_q;

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_rsp
    assign rsp_msg[g*32 +: 32] = rsp[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      tsize    <= '0;
      rsize    <= '0;
      nresp    <= 1'b0;
      init_q   <= 1'b1;
      tmr      <= '0;
      status_q <= ST_OK;
      for (int i = 0; i < MAX_WORDS; i++) begin
        msg[i] <= '0;
        rsp[i] <= '0;
      end
    end else begin
      init_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < MAX_WORDS; i++) begin
            msg[i] <= req_msg[i*32 +: 32];
            rsp[i] <= '0;
          end
          tsize <= req_msg[15:8];
          nresp <= no_resp;
          idx   <= '0;
          tmr   <= TW'(TIMEOUT_CYC - 1);
          if (req_msg[15:8] > 8'(MAX_WORDS)) begin
            status_q <= ST_INV;
            st       <= S_DONE;
          end else begin
            st <= S_TX;
          end
        end
        S_TX: if (tx_empty[ch]) begin
          tmr <= TW'(TIMEOUT_CYC - 1);
          if (last_tx) begin
            idx <= '0;
            if (nresp) begin
              status_q <= ST_OK;
              st       <= S_DONE;
            end else begin
              st <= S_RX;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end else if (tmr == '0) begin
          status_q <= ST_TMO;
          st       <= S_DONE;
        end else begin
          tmr <= tmr - 1'b1;
        end
        S_RX: if (rx_full[ch]) begin
          tmr      <= TW'(TIMEOUT_CYC - 1);
          rsp[idx] <= cur_rx;
          if (idx == '0) rsize <= cur_rx[15:8];
          if (idx == '0 && hdr_bad) begin
            rsp[0]   <= '0;
            status_q <= ST_INV;
            st       <= S_DONE;
          end else if (last_rx) begin
            status_q <= (lowb == 8'd0) ? ST_OK : ST_IOE;
            st       <= S_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end else if (tmr == '0) begin
          status_q <= ST_TMO;
          st       <= S_DONE;
        end else begin
          tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_tx_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_wr) && $onehot0(rx_rd));
  assert_tx_wr_empty_R3: assert property (@(posedge clk) disable iff (!rst_n) (tx_wr & ~tx_empty) == '0);
  assert_rx_rd_full_R4: assert property (@(posedge clk) disable iff (!rst_n) (rx_rd & ~rx_full) == '0);
  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(status));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_init_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n) ctl_clr |=> !ctl_clr);
endmodule

// File: tb/sim_mbox_msg_engine.sv
module sim_mbox_msg_engine;
  localparam int MW = 8, NC = 4, TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, no_resp = 1'b0;
  logic [MW*32-1:0] req_msg;
  logic busy, done, ctl_clr;
  logic [1:0] status;
  logic [MW*32-1:0] rsp_msg;
  logic [NC-1:0] tx_empty, tx_wr, rx_full, rx_rd;
  logic [NC-1:0] tx_blk = '0;
  logic [31:0] tx_data;
  logic [NC*32-1:0] rx_data;

  always #4 clk = ~clk;

  mbox_msg_engine #(.MAX_WORDS(MW), .NCH(NC), .TIMEOUT_CYC(TMO)) u0 (
    .clk, .rst_n, .start, .no_resp, .req_msg, .busy, .done, .status, .rsp_msg,
    .ctl_clr, .tx_empty, .tx_wr, .tx_data, .rx_full, .rx_rd, .rx_data);

  int total = 0, bad = 0;
  logic [31:0] req_w [MW];
  logic [31:0] rsp_mem [MW];
  int rsp_n = 0;
  int ptr [NC];

  assign tx_empty = ~tx_blk;
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      int k;
      k = c + NC * ptr[c];
      rx_full[c] = (k < rsp_n) && (k < MW);
      rx_data[c*32 +: 32] = (k < MW) ? rsp_mem[k] : 32'h0;
    end
  end
  always @(posedge clk)
    for (int c = 0; c < NC; c++) if (rx_rd[c]) ptr[c] <= ptr[c] + 1;

  typedef struct {string req; logic [1:0] st; int nsent; int nrd; logic [31:0] rsp0;} exp_t;
  exp_t expq[$];
  logic [33:0] txq[$];
  string txreq;
  int nsent = 0, nrd = 0, ndone = 0, ntxn = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (tx_wr != '0) begin
      nsent++;
      if (txq.size() == 0) check({txreq, " unexpected tx"}, 64'(tx_wr), 64'h0);
      else begin
        logic [33:0] e;
        e = txq.pop_front();
        check({txreq, " tx word"}, {30'h0, 2'($clog2(tx_wr)), tx_data}, {30'h0, e});
      end
    end
    if (rx_rd != '0) nrd++;
    if (done) begin
      ndone++;
      if (expq.size() == 0) check("R11 extra done", 64'h1, 64'h0);
      else begin
        exp_t e;
        e = expq.pop_front();
        check({e.req, " status"}, 64'(status), 64'(e.st));
        check({e.req, " words sent"}, 64'(nsent), 64'(e.nsent));
        check({e.req, " words read"}, 64'(nrd), 64'(e.nrd));
        check({e.req, " reply word0"}, 64'(rsp_msg[31:0]), 64'(e.rsp0));
        check({e.req, " busy low at done"}, 64'(busy), 64'h0);
      end
      nsent = 0;
      nrd = 0;
    end
  end

  task automatic go(string req, bit nr, logic [1:0] est, int ens, int enr, logic [31:0] er0, int stall);
    exp_t e;
    e.req = req; e.st = est; e.nsent = ens; e.nrd = enr; e.rsp0 = er0;
    expq.push_back(e);
    txreq = req;
    for (int k = 0; k < ens; k++) txq.push_back({2'(k % NC), req_w[k]});
    for (int k = 0; k < MW; k++) req_msg[k*32 +: 32] = req_w[k];
    for (int c = 0; c < NC; c++) ptr[c] = 0;
    ntxn++;
    @(posedge clk); #1 start = 1'b1; no_resp = nr;
    @(posedge clk); #1 start = 1'b0;
    if (stall > 0) begin
      repeat (stall / 2) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (stall / 2) @(posedge clk);
      #1 tx_blk = '0;
    end
    do @(negedge clk); while (!done);
    @(posedge clk); #1;
    check({req, " tx queue drained"}, 64'(txq.size()), 64'h0);
    txq.delete();
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < MW; k++) begin req_w[k] = '0; rsp_mem[k] = '0; end
    for (int c = 0; c < NC; c++) ptr[c] = 0;
    req_msg = '0;
    repeat (3) @(negedge clk);
    check("R10 reset busy", 64'(busy), 64'h0);
    check("R10 reset done", 64'(done), 64'h0);
    check("R10 reset status", 64'(status), 64'h0);
    #1 rst_n = 1'b1;
    #1 check("R12 clear strobe high", 64'(ctl_clr), 64'h1);
    @(negedge clk) check("R12 clear strobe low", 64'(ctl_clr), 64'h0);

    // R1 R2 R8: two-word command, reply payload low byte 0
    req_w[0] = 32'h17C40206; req_w[1] = 32'h3;
    rsp_mem[0] = 32'hE1C40206; rsp_mem[1] = 32'h0; rsp_n = 2;
    go("R1 R8 short command ok", 1'b0, 2'd0, 2, 2, 32'hE1C40206, 0);
    check("R4 reply word1", 64'(rsp_msg[63:32]), 64'h0);

    // R2 R4: eight words each way, channel wraps
    for (int k = 0; k < MW; k++) begin req_w[k] = 32'hA000_0000 + k; rsp_mem[k] = 32'hB000_0000 + k; end
    req_w[0] = 32'h17110806; rsp_mem[0] = 32'hE1110806; rsp_mem[1] = 32'h1234_5600; rsp_n = 8;
    go("R2 eight words rotate", 1'b0, 2'd0, 8, 8, 32'hE1110806, 0);
    check("R4 reply word7", 64'(rsp_msg[7*32 +: 32]), 64'hB000_0007);
    check("R4 reply word5", 64'(rsp_msg[5*32 +: 32]), 64'hB000_0005);

    // R8: nonzero low byte
    req_w[0] = 32'h17C40206; req_w[1] = 32'h1;
    rsp_mem[0] = 32'hE1C40306; rsp_mem[1] = 32'h0000_002A; rsp_mem[2] = 32'h55; rsp_n = 3;
    go("R8 io error", 1'b0, 2'd3, 2, 3, 32'hE1C40306, 0);

    // R5: oversized request
    req_w[0] = 32'h17C40906;
    go("R5 request too long", 1'b0, 2'd1, 0, 0, 32'h0, 0);

    // R6: oversized reply header
    req_w[0] = 32'h17C40106;
    rsp_mem[0] = 32'hE1C40C06; rsp_n = 4;
    go("R6 reply too long", 1'b0, 2'd1, 1, 1, 32'h0, 0);

    // R7: no reply
    req_w[0] = 32'h17200306; req_w[1] = 32'h7; req_w[2] = 32'h9; rsp_n = 0;
    go("R7 no reply", 1'b1, 2'd0, 3, 0, 32'h0, 0);

    // R9: transmit slot 1 never empties
    req_w[0] = 32'h17C40206; tx_blk = 4'b0010;
    go("R9 tx timeout", 1'b0, 2'd2, 1, 0, 32'h0, 0);
    tx_blk = '0;

    // R9: reply header promises two words, only one arrives
    rsp_mem[0] = 32'hE1C40206; rsp_n = 1;
    go("R9 rx timeout", 1'b0, 2'd2, 2, 1, 32'hE1C40206, 0);

    // R3 R11: slot 0 stalls 20 cycles, stray start mid-stall
    req_w[0] = 32'h17C40206; req_w[1] = 32'h5;
    rsp_mem[0] = 32'hE1C40206; rsp_mem[1] = 32'h0; rsp_n = 2; tx_blk = 4'b0001;
    go("R3 R11 stalled slot", 1'b0, 2'd0, 2, 2, 32'hE1C40206, 20);

    // R8: one-word reply treated as ok
    rsp_mem[0] = 32'hE1C40106; rsp_n = 1;
    go("R8 header-only reply", 1'b0, 2'd0, 2, 1, 32'hE1C40106, 0);

    repeat (4) @(negedge clk);
    check("R11 completions", 64'(ndone), 64'(ntxn));
    check("R10 scoreboard empty", 64'(expq.size()), 64'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule